// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block receives asynchronous 11-bit serial frames and hands each accepted frame to the logic behind it. A frame is a low start bit, nine data bits sent least significant bit first, and a high stop bit. The lower eight data bits form the received byte. The ninth bit is used either to mark an address frame or to carry parity. The line is oversampled with a single-cycle tick that runs at sixteen times the bit rate; the tick is generated elsewhere. The line first passes through a short synchronizer.

Two receive behaviours are selected by `addr_mode`.

- **Address filtering** (`addr_mode` = 1): only frames whose ninth bit is 1 are delivered. Other frames are dropped silently. This lets a node on a shared link ignore traffic until it is addressed.
- **Plain nine-bit reception** (`addr_mode` = 0): every well-formed frame is delivered. The status bit then holds either the raw ninth bit or, when `par_en` is set, an even-parity error indication.

A frame whose stop bit is sampled low raises `frm_err` and is not delivered.

Received bytes leave on a valid/ready stream. `rx_valid` stays high, with `rx_data` and `rx_stat` stable, until a cycle in which `rx_ready` is high. That cycle consumes the byte, and `rx_valid` drops at the following clock edge. A serial line cannot be paused. So back-pressure never stalls reception: a frame accepted while an earlier byte is still waiting replaces it, and `rx_valid` stays high.

Top module: `sio9_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `rx_stat` and `frm_err` are all 0.
- R2: A frame is a 0 start bit, nine data bits with the least significant bit first, and a 1 stop bit. Bits 0 to 7 of a delivered frame appear on `rx_data`, with bit 0 as `rx_data[0]`.
- R3: A start bit is confirmed only if the line is still low at the ninth tick of the bit, counting the tick that first saw it low as tick 0. A shorter low pulse returns the receiver to idle and delivers nothing. The receiver then decodes the next real frame correctly.
- R4: With `addr_mode` = 1, a frame raises `rx_valid` only when its ninth bit is 1, and `rx_stat` then shows that ninth bit.
- R5: With `addr_mode` = 1, a frame whose ninth bit is 0 leaves `rx_valid`, `rx_data` and `rx_stat` unchanged.
- R6: With `addr_mode` = 0, every frame with a valid stop bit raises `rx_valid`, whatever its ninth bit.
- R7: With `addr_mode` = 0 and `par_en` = 0, `rx_stat` equals the received ninth bit.
- R8: With `addr_mode` = 0 and `par_en` = 1, `rx_stat` is 1 exactly when the XOR of the eight data bits and the ninth bit is 1. This is an even-parity error.
- R9: With `addr_mode` = 1, `par_en` has no effect: `rx_stat` still shows the raw ninth bit.
- R10: Delivery happens on the clock edge of the last tick of the stop bit. That is tick 175, counting the first tick that saw the start bit low as tick 0. `rx_valid` is still low one tick earlier.
- R11: A stop bit sampled low sets `frm_err` to 1, raises no `rx_valid`, and leaves `rx_data` unchanged. `frm_err` returns to 0 when the next frame ends with a high stop bit.
- R12: `rx_valid` stays high until a clock edge where `rx_ready` is 1, and drops at that edge. A frame delivered while `rx_valid` is high replaces `rx_data` and `rx_stat` and keeps `rx_valid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rxd | input | 1 | Serial line, idles high |
| addr_mode | input | 1 | 1: deliver only frames whose ninth bit is 1; 0: deliver all frames |
| par_en | input | 1 | In mode 0, makes `rx_stat` an even-parity error flag |
| rx_ready | input | 1 | Consumer accepts the waiting byte |
| rx_valid | output | 1 | A received byte is waiting |
| rx_data | output | 8 | Received byte |
| rx_stat | output | 1 | Ninth bit or parity error |
| frm_err | output | 1 | Last completed frame had a low stop bit |

## Verification
All results appear on the clock edge of tick 175 of a frame, counting the first tick that saw the start bit low as tick 0. A consuming `rx_ready` clears `rx_valid` on the next edge. The bench places each tick three clock cycles after any line change, so the two-stage synchronizer has settled before the tick samples the line. It holds each bit for exactly sixteen ticks. Outputs are sampled on the falling clock edge after the tick whose edge is due. For the timing check, the bench stops one tick short of the frame end, confirms `rx_valid` is low, then issues the final tick and confirms it is high.

// File: rtl/sio9_rx_pkg.sv
package sio9_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/sio9_rx_sampler.sv
// Line synchronizer, start qualification and bit-timing state machine.
module sio9_rx_sampler
  import sio9_rx_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int NBITS       = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic samp_en,
  output logic samp_bit,
  output logic frame_done,
  output logic stop_ok
);
  localparam int PH_W = $clog2(OVS);
  localparam int BN_W = $clog2(NBITS);
  localparam logic [PH_W-1:0] PH_MID  = PH_W'(OVS / 2);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(OVS - 1);
  localparam logic [BN_W-1:0] BN_LAST = BN_W'(NBITS - 1);

  logic line;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign line = rxd;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
      assign line = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  rx_state_e       st;
  logic [PH_W-1:0] ph;
  logic [BN_W-1:0] bn;
  logic            at_mid, at_last;

  assign at_mid     = tick && (ph == PH_MID);
  assign at_last    = tick && (ph == PH_LAST);
  assign samp_en    = (st == ST_DATA) && at_mid;
  assign samp_bit   = line;
  assign frame_done = (st == ST_STOP) && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph      <= '0;
      bn      <= '0;
      stop_ok <= 1'b0;
    end else begin
      if (st == ST_IDLE) begin
        if (tick && !line) begin
          st <= ST_START;
          ph <= PH_W'(1);
        end
      end else if (tick) begin
        ph <= at_last ? '0 : ph + PH_W'(1);
        case (st)
          ST_START: begin
            if (at_mid && line) begin
              st <= ST_IDLE;
              ph <= '0;
            end else if (at_last) begin
              st <= ST_DATA;
              bn <= '0;
            end
          end
          ST_DATA: begin
            if (at_last) begin
              if (bn == BN_LAST) st <= ST_STOP;
              else               bn <= bn + BN_W'(1);
            end
          end
          ST_STOP: begin
            if (at_mid)  stop_ok <= line;
            if (at_last) st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sio9_rx_shreg.sv
// Least-significant-first assembly register.
module sio9_rx_shreg #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)        q <= '0;
    else if (shift_en) q <= {bit_in, q[W-1:1]};
  end
endmodule

// File: rtl/sio9_rx_out.sv
// Filter, status selection and output stream register.
module sio9_rx_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic              stop_ok,
  input  logic [DATA_W:0]   frame,
  input  logic              addr_mode,
  input  logic              par_en,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stat,
  output logic              frm_err
);
  logic ninth, perr, pass, stat_nxt;

  assign ninth    = frame[DATA_W];
  assign perr     = ^frame;
  assign pass     = stop_ok && (addr_mode ? ninth : 1'b1);
  assign stat_nxt = (!addr_mode && par_en) ? perr : ninth;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      rx_stat  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) rx_valid <= 1'b0;
      if (frame_done) begin
        frm_err <= !stop_ok;
        if (pass) begin
          rx_valid <= 1'b1;
          rx_data  <= frame[DATA_W-1:0];
          rx_stat  <= stat_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/sio9_rx.sv
module sio9_rx #(
  parameter int OVS         = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              addr_mode,
  input  logic              par_en,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_stat,
  output logic              frm_err
);
  localparam int NBITS = DATA_W + 1;

  logic             samp_en, samp_bit, frame_done, stop_ok;
  logic [NBITS-1:0] frame_q;

  sio9_rx_sampler #(
    .OVS(OVS), .NBITS(NBITS), .SYNC_STAGES(SYNC_STAGES)
  ) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
    .samp_en(samp_en), .samp_bit(samp_bit),
    .frame_done(frame_done), .stop_ok(stop_ok)
  );

  sio9_rx_shreg #(.W(NBITS)) u_shreg (
    .clk(clk), .rst_n(rst_n), .shift_en(samp_en), .bit_in(samp_bit), .q(frame_q)
  );

  sio9_rx_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .stop_ok(stop_ok),
    .frame(frame_q), .addr_mode(addr_mode), .par_en(par_en),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_stat(rx_stat), .frm_err(frm_err)
  );
endmodule

// File: rtl/sio9_rx_chk.sv
module sio9_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              addr_mode,
  input logic              rx_ready,
  input logic              rx_valid,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_stat,
  input logic              frm_err,
  input logic              frame_done,
  input logic              stop_ok,
  input logic              frame_ninth
);
  AST_VALID_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(frame_done)); // R6
  AST_ADDR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && addr_mode && !frame_ninth && !rx_valid |=> !rx_valid); // R4
  AST_ADDR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && addr_mode && !frame_ninth |=> $stable(rx_data) && $stable(rx_stat)); // R5
  AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && addr_mode && frame_ninth && stop_ok |=> rx_valid && rx_stat); // R4
  AST_BAD_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !stop_ok |=> frm_err && $stable(rx_data)); // R11
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid); // R12
endmodule

bind sio9_rx sio9_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_mode(addr_mode), .rx_ready(rx_ready),
  .rx_valid(rx_valid), .rx_data(rx_data), .rx_stat(rx_stat), .frm_err(frm_err),
  .frame_done(frame_done), .stop_ok(stop_ok), .frame_ninth(frame_q[DATA_W])
);

// File: tb/sio9_rx_test.sv
module sio9_rx_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       addr_mode = 1'b0;
  logic       par_en = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_stat;
  logic       frm_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sio9_rx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
    .addr_mode(addr_mode), .par_en(par_en), .rx_ready(rx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_stat(rx_stat), .frm_err(frm_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Each tick lands three cycles after any line change, one cycle wide.
  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      repeat (3) @(negedge clk);
      tick16 = 1'b1;
      @(negedge clk);
      tick16 = 1'b0;
    end
  endtask

  // Sends a frame; with hold_last the final stop tick is left to the caller.
  task automatic drive_frame(input logic [7:0] d, input logic b9, input logic sbit,
                             input bit hold_last);
    logic [10:0] bits;
    bits = {sbit, b9, d, 1'b0};
    for (int i = 0; i < 11; i++) begin
      rxd = bits[i];
      tk((i == 10 && hold_last) ? 15 : 16);
    end
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic sbit);
    drive_frame(d, b9, sbit, 1'b0);
    rxd = 1'b1;
    tk(2);
  endtask

  task automatic take();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    chk("R12 valid cleared by ready", rx_valid, 1'b0);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", rx_valid, 1'b0);
    chk("R1 data", rx_data, 8'h00);
    chk("R1 stat", rx_stat, 1'b0);
    chk("R1 frm_err", frm_err, 1'b0);
    tk(2);
  endtask

  task automatic t_plain();
    addr_mode = 1'b0; par_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1);
    chk("R6 valid ninth=0", rx_valid, 1'b1);
    chk("R2 data A5", rx_data, 8'hA5);
    chk("R7 stat ninth=0", rx_stat, 1'b0);
    take();
    send(8'h3C, 1'b1, 1'b1);
    chk("R6 valid ninth=1", rx_valid, 1'b1);
    chk("R2 data 3C", rx_data, 8'h3C);
    chk("R7 stat ninth=1", rx_stat, 1'b1);
    take();
    send(8'h01, 1'b0, 1'b1);
    chk("R2 lsb first 01", rx_data, 8'h01);
    take();
  endtask

  task automatic t_parity();
    logic [7:0] d;
    logic       b;
    addr_mode = 1'b0; par_en = 1'b1;
    for (int k = 0; k < 4; k++) begin
      d = (k < 2) ? 8'h07 : 8'hF0;
      b = k[0];
      send(d, b, 1'b1);
      chk("R8 valid", rx_valid, 1'b1);
      chk("R8 parity err", rx_stat, ^{d, b});
      take();
    end
    par_en = 1'b0;
  endtask

  task automatic t_addr();
    addr_mode = 1'b1; par_en = 1'b0;
    send(8'h5A, 1'b1, 1'b1);
    chk("R4 address frame valid", rx_valid, 1'b1);
    chk("R4 address data", rx_data, 8'h5A);
    chk("R4 stat", rx_stat, 1'b1);
    take();
    send(8'h33, 1'b0, 1'b1);
    chk("R4 filtered no valid", rx_valid, 1'b0);
    chk("R5 data kept", rx_data, 8'h5A);
    chk("R5 stat kept", rx_stat, 1'b1);
    par_en = 1'b1;
    send(8'h01, 1'b1, 1'b1);
    chk("R9 valid", rx_valid, 1'b1);
    chk("R9 stat raw ninth", rx_stat, 1'b1);
    take();
    par_en = 1'b0;
    addr_mode = 1'b0;
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    tk(6);
    rxd = 1'b1;
    tk(30);
    chk("R3 glitch no valid", rx_valid, 1'b0);
    send(8'hC3, 1'b0, 1'b1);
    chk("R3 resync valid", rx_valid, 1'b1);
    chk("R3 resync data", rx_data, 8'hC3);
    take();
  endtask

  task automatic t_framing();
    send(8'h99, 1'b1, 1'b0);
    chk("R11 frm_err set", frm_err, 1'b1);
    chk("R11 no valid", rx_valid, 1'b0);
    chk("R11 data kept", rx_data, 8'hC3);
    send(8'h42, 1'b0, 1'b1);
    chk("R11 frm_err cleared", frm_err, 1'b0);
    chk("R11 next valid", rx_valid, 1'b1);
    chk("R11 next data", rx_data, 8'h42);
    take();
  endtask

  task automatic t_timing();
    drive_frame(8'h6E, 1'b0, 1'b1, 1'b1);
    chk("R10 not yet valid", rx_valid, 1'b0);
    tk(1);
    chk("R10 valid at last stop tick", rx_valid, 1'b1);
    chk("R10 data", rx_data, 8'h6E);
    rxd = 1'b1;
    tk(2);
    take();
  endtask

  task automatic t_backpressure();
    send(8'h11, 1'b0, 1'b1);
    tk(10);
    chk("R12 valid held", rx_valid, 1'b1);
    chk("R12 data held", rx_data, 8'h11);
    send(8'h22, 1'b1, 1'b1);
    chk("R12 still valid", rx_valid, 1'b1);
    chk("R12 replaced data", rx_data, 8'h22);
    chk("R12 replaced stat", rx_stat, 1'b1);
    take();
  endtask

  initial begin
    t_reset();
    t_plain();
    t_parity();
    t_addr();
    t_glitch();
    t_framing();
    t_timing();
    t_backpressure();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule